// File: doc/BRIEF.md
# Secondary-Side Uncorrectable Error Reporter

This unit sits on the secondary side of a PCIe-to-PCI bridge and turns single-cycle error pulses from that bus into register state and error-message requests toward the PCIe side. Three sources feed it. The first is a data parity error. The second is the system-error pin being seen asserted. The third is a master-abort received on a posted write. Every pulse comes with the header of the transaction it hit. The unit keeps status, mask and severity registers, a first-error pointer and a header log. It also holds the legacy status bits and the device-level detected bits.

Software accesses the registers through a flat, single-cycle port. Writes take effect at the clock edge and reads are combinational. Error messages leave as two request lines, one for fatal and one for non-fatal, and each uses a valid/ready handshake. For each system-error-pin pulse and each master-abort pulse, the unit also gives a one-cycle hint to the forwarding logic: continue the transaction, or discard it.

Top module: `bridge_err_report`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero except the severity register, which reads the parameter `SEV_RST` (default 3'b010). Both message-valid outputs and both forwarding hints are low.
- R2: Source index 0 is parity, 1 is system-error pin and 2 is master-abort. A pulse sets bit i of the status register (address 0) on the next edge. Writing a 1 to a status bit clears it. When an event and a clear hit the same bit in the same cycle, the bit stays set.
- R3: An unmasked parity pulse always takes the first-error pointer, even when the pointer is already valid, and copies the header into the header log (address 4). The pointer register (address 3) holds the source index in bits [1:0] and the valid flag in bit 4.
- R4: A system-error-pin pulse never writes the header log. It takes the pointer only when the pointer is invalid and its mask bit (address 1, bit 1) is clear.
- R5: An unmasked master-abort pulse takes the pointer and logs the header only when the pointer is invalid.
- R6: When several pulses arrive in one cycle and more than one would take the pointer, the lowest source index wins: parity, then system-error pin, then master-abort. The header is logged only if the winner is a header-logging source.
- R7: The pointer becomes invalid when the status bit it points to is cleared and no new pulse takes the pointer in that cycle.
- R8: A pulse requests a message only if its mask bit is clear and either the legacy enable (address 5, bit 0) is set or the device enable for its severity is set. Bit 1 is the fatal enable and bit 2 is the non-fatal enable. The severity bit (address 2, 1 = fatal) picks the fatal or the non-fatal request line.
- R9: A request becomes valid on the edge after its pulse. It stays valid until the edge where ready is high. Pending requests of the same severity merge into one.
- R10: Legacy status bit 0 (address 6) sets only when a message is requested in that cycle while the legacy enable is set. All legacy status bits are write-one-to-clear.
- R11: Every pulse, masked or not, sets device status (address 7) bit 0 if its severity is fatal and bit 1 if non-fatal. These bits are write-one-to-clear.
- R12: A system-error-pin pulse raises `fwd_continue` for the next cycle and sets legacy status bit 1. A master-abort pulse raises `fwd_discard` for the next cycle and sets legacy status bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_par | input | 1 | Data parity error pulse |
| ev_spin | input | 1 | System-error pin seen asserted |
| ev_mabt | input | 1 | Master-abort on a posted write |
| ev_hdr | input | HDR_W | Header of the affected transaction |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| msg_fatal_vld | output | 1 | Fatal message request pending |
| msg_fatal_rdy | input | 1 | Fatal request accepted |
| msg_nf_vld | output | 1 | Non-fatal message request pending |
| msg_nf_rdy | input | 1 | Non-fatal request accepted |
| fwd_discard | output | 1 | Discard the whole posted write |
| fwd_continue | output | 1 | Keep forwarding the transaction |

## Verification
The bench aims at the pointer rules. A parity pulse arrives while the pointer is already valid. A system-error or master-abort pulse arrives after that. Then all three pulses land in one cycle. A design that treated every source alike would move the pointer or overwrite the header log where it must not. A second group of cases clears a status bit in the same cycle that a pulse sets it, or clears the bit the pointer names. Getting this wrong either loses the error or leaves the pointer valid on a cleared bit. The last group holds ready low over repeated pulses and toggles the enables one at a time. A wrong gating term or a dropped request then shows up on the valid lines or in legacy bit 0.

// File: rtl/bre_pkg.sv
// Shared constants for the secondary-side error reporter.
// Assumes three sources whose index order is also the pointer priority order.
package bre_pkg;
    localparam int NSRC  = 3;
    localparam int PTR_W = 2;
    localparam int DW    = 32;
    localparam int SRC_PAR  = 0;
    localparam int SRC_SPIN = 1;
    localparam int SRC_MABT = 2;
    // sources that overwrite a valid pointer
    localparam logic [NSRC-1:0] TAKE_ALWAYS = 3'b001;
    // sources that copy the header when they win the pointer
    localparam logic [NSRC-1:0] LOGS_HDR    = 3'b101;
    localparam int NSEV = 2;   // 0 fatal, 1 non-fatal
    localparam int CTL_LEGACY = 0;
    localparam int CTL_FATAL  = 1;
    localparam int CTL_NONFAT = 2;
    typedef enum logic [2:0] {
        A_STAT = 3'd0, A_MASK = 3'd1, A_SEV = 3'd2, A_FEP = 3'd3,
        A_HLOG = 3'd4, A_CTRL = 3'd5, A_LEG = 3'd6, A_DEV  = 3'd7
    } reg_addr_e;
endpackage

// File: rtl/err_src_eval.sv
// Per-source decision logic: decides whether each pulse requests a message
// and whether it claims the first-error pointer. Purely combinational.
// Assumes the mask, severity and enables are the registered values of this cycle.
module err_src_eval
    import bre_pkg::*;
(
    input  logic [NSRC-1:0] ev,
    input  logic [NSRC-1:0] mask,
    input  logic [NSRC-1:0] sev,
    input  logic            legacy_en,
    input  logic            fatal_en,
    input  logic            nf_en,
    input  logic            fep_valid,
    output logic [NSRC-1:0] claim,
    output logic            req_fatal,
    output logic            req_nf,
    output logic            det_fatal,
    output logic            det_nf
);
    logic [NSRC-1:0] req;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        logic dev_en;
        // device enable chosen by this source's severity
        assign dev_en   = sev[i] ? fatal_en : nf_en;
        assign req[i]   = ev[i] & ~mask[i] & (legacy_en | dev_en);
        assign claim[i] = ev[i] & ~mask[i] & (TAKE_ALWAYS[i] | ~fep_valid);
    end

    // fold per-source results by severity
    always_comb begin
        req_fatal = |(req & sev);
        req_nf    = |(req & ~sev);
        det_fatal = |(ev & sev);
        det_nf    = |(ev & ~sev);
    end
endmodule

// File: rtl/err_fep_sel.sv
// Fixed-priority selection of the source that owns the first-error pointer.
// Lowest index wins. Assumes claims are already qualified by mask and validity.
module err_fep_sel
    import bre_pkg::*;
(
    input  logic [NSRC-1:0]  claim,
    output logic             win_valid,
    output logic [PTR_W-1:0] win_idx,
    output logic             win_logs
);
    // scan from the lowest priority up so the highest priority ends last
    always_comb begin
        win_idx = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (claim[i]) win_idx = PTR_W'(i);
        end
        win_valid = |claim;
        win_logs  = win_valid & LOGS_HDR[win_idx];
    end
endmodule

// File: rtl/err_msg_pend.sv
// One pending message request with a valid/ready handshake.
// A new request merges into a pending one. Acceptance drops valid unless a new one arrives.
module err_msg_pend (
    input  logic clk,
    input  logic rst_n,
    input  logic new_req,
    input  logic rdy,
    output logic vld
);
    // hold the request until accepted
    always_ff @(posedge clk) begin
        if (!rst_n) vld <= 1'b0;
        else        vld <= (vld & ~rdy) | new_req;
    end
endmodule

// File: rtl/bridge_err_report.sv
// Secondary-side uncorrectable error reporter: register bank, pointer and header
// log, message requests and forwarding hints. Synchronous active-low reset.
// Assumes event pulses last one cycle and HDR_W does not exceed the data width.
module bridge_err_report
    import bre_pkg::*;
#(
    parameter int              HDR_W   = 32,
    parameter logic [NSRC-1:0] SEV_RST = 3'b010
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_par,
    input  logic             ev_spin,
    input  logic             ev_mabt,
    input  logic [HDR_W-1:0] ev_hdr,
    input  logic             reg_wr_en,
    input  logic [2:0]       reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    output logic             msg_fatal_vld,
    input  logic             msg_fatal_rdy,
    output logic             msg_nf_vld,
    input  logic             msg_nf_rdy,
    output logic             fwd_discard,
    output logic             fwd_continue
);
    localparam int SEL_BITS = 3;

    logic [NSRC-1:0]  ev;
    logic [NSRC-1:0]  stat_q, stat_d, stat_clr;
    logic [NSRC-1:0]  mask_q, sev_q;
    logic [2:0]       ctl_q, leg_q, leg_set, leg_clr;
    logic [1:0]       dev_q, dev_set, dev_clr;
    logic [PTR_W-1:0] fep_idx_q;
    logic             fep_valid_q;
    logic [HDR_W-1:0] hlog_q;
    logic [NSRC-1:0]  claim;
    logic             req_fatal, req_nf, det_fatal, det_nf;
    logic             win_valid, win_logs;
    logic [PTR_W-1:0] win_idx;
    logic [NSEV-1:0]  pend_new, pend_rdy, pend_vld;
    logic             wdata_unused;

    assign ev = {ev_mabt, ev_spin, ev_par};
    assign wdata_unused = ^reg_wdata[DW-1:SEL_BITS];

    err_src_eval u_eval (
        .ev        (ev),
        .mask      (mask_q),
        .sev       (sev_q),
        .legacy_en (ctl_q[CTL_LEGACY]),
        .fatal_en  (ctl_q[CTL_FATAL]),
        .nf_en     (ctl_q[CTL_NONFAT]),
        .fep_valid (fep_valid_q),
        .claim     (claim),
        .req_fatal (req_fatal),
        .req_nf    (req_nf),
        .det_fatal (det_fatal),
        .det_nf    (det_nf)
    );

    err_fep_sel u_sel (
        .claim     (claim),
        .win_valid (win_valid),
        .win_idx   (win_idx),
        .win_logs  (win_logs)
    );

    assign pend_new = {req_nf, req_fatal};
    assign pend_rdy = {msg_nf_rdy, msg_fatal_rdy};

    for (genvar s = 0; s < NSEV; s++) begin : g_pend
        err_msg_pend u_pend (
            .clk     (clk),
            .rst_n   (rst_n),
            .new_req (pend_new[s]),
            .rdy     (pend_rdy[s]),
            .vld     (pend_vld[s])
        );
    end
    assign msg_fatal_vld = pend_vld[0];
    assign msg_nf_vld    = pend_vld[1];

    // write-one-to-clear decode and set terms for sticky bits
    always_comb begin
        stat_clr = (reg_wr_en && reg_addr == A_STAT) ? reg_wdata[NSRC-1:0] : '0;
        leg_clr  = (reg_wr_en && reg_addr == A_LEG)  ? reg_wdata[2:0] : '0;
        dev_clr  = (reg_wr_en && reg_addr == A_DEV)  ? reg_wdata[1:0] : '0;
        stat_d   = (stat_q & ~stat_clr) | ev;
        leg_set  = {ev_mabt, ev_spin, ctl_q[CTL_LEGACY] & (req_fatal | req_nf)};
        dev_set  = {det_nf, det_fatal};
    end

    // sticky status, legacy and device bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
            leg_q  <= '0;
            dev_q  <= '0;
        end else begin
            stat_q <= stat_d;
            leg_q  <= (leg_q & ~leg_clr) | leg_set;
            dev_q  <= (dev_q & ~dev_clr) | dev_set;
        end
    end

    // software-owned configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            sev_q  <= SEV_RST;
            ctl_q  <= '0;
        end else if (reg_wr_en) begin
            if (reg_addr == A_MASK) mask_q <= reg_wdata[NSRC-1:0];
            if (reg_addr == A_SEV)  sev_q  <= reg_wdata[NSRC-1:0];
            if (reg_addr == A_CTRL) ctl_q  <= reg_wdata[2:0];
        end
    end

    // first-error pointer and header log
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fep_idx_q   <= '0;
            fep_valid_q <= 1'b0;
            hlog_q      <= '0;
        end else if (win_valid) begin
            fep_idx_q   <= win_idx;
            fep_valid_q <= 1'b1;
            if (win_logs) hlog_q <= ev_hdr;
        end else begin
            fep_valid_q <= fep_valid_q & stat_d[fep_idx_q];
        end
    end

    // one-cycle forwarding hints
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_discard  <= 1'b0;
            fwd_continue <= 1'b0;
        end else begin
            fwd_discard  <= ev_mabt;
            fwd_continue <= ev_spin;
        end
    end

    // register read mux
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_STAT:  reg_rdata[NSRC-1:0]  = stat_q;
            A_MASK:  reg_rdata[NSRC-1:0]  = mask_q;
            A_SEV:   reg_rdata[NSRC-1:0]  = sev_q;
            A_FEP:   reg_rdata[4:0]       = {fep_valid_q, 2'b00, fep_idx_q};
            A_HLOG:  reg_rdata[HDR_W-1:0] = hlog_q;
            A_CTRL:  reg_rdata[2:0]       = ctl_q;
            A_LEG:   reg_rdata[2:0]       = leg_q;
            default: reg_rdata[1:0]       = dev_q;
        endcase
    end
endmodule

// File: rtl/bre_checker.sv
// Temporal checks for the error reporter, bound to every instance of the top.
module bre_checker
    import bre_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             ev_par,
    input logic             ev_spin,
    input logic             ev_mabt,
    input logic             msg_fatal_vld,
    input logic             msg_fatal_rdy,
    input logic             msg_nf_vld,
    input logic             msg_nf_rdy,
    input logic             fwd_discard,
    input logic             fwd_continue,
    input logic [NSRC-1:0]  stat_q,
    input logic             fep_valid_q,
    input logic [PTR_W-1:0] fep_idx_q
);
    a_r2_parity_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
        ev_par |=> stat_q[SRC_PAR]);
    a_r12_discard_hint: assert property (@(posedge clk) disable iff (!rst_n)
        ev_mabt |=> fwd_discard);
    a_r12_continue_hint: assert property (@(posedge clk) disable iff (!rst_n)
        ev_spin |=> fwd_continue);
    a_r9_fatal_held: assert property (@(posedge clk) disable iff (!rst_n)
        msg_fatal_vld && !msg_fatal_rdy |=> msg_fatal_vld);
    a_r9_nf_held: assert property (@(posedge clk) disable iff (!rst_n)
        msg_nf_vld && !msg_nf_rdy |=> msg_nf_vld);
    a_r7_pointer_names_set_bit: assert property (@(posedge clk) disable iff (!rst_n)
        fep_valid_q |-> stat_q[fep_idx_q]);
    a_r8_fatal_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_fatal_vld) |-> $past(ev_par | ev_spin | ev_mabt));
    a_r8_nf_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_nf_vld) |-> $past(ev_par | ev_spin | ev_mabt));
endmodule

bind bridge_err_report bre_checker u_bre_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .ev_par        (ev_par),
    .ev_spin       (ev_spin),
    .ev_mabt       (ev_mabt),
    .msg_fatal_vld (msg_fatal_vld),
    .msg_fatal_rdy (msg_fatal_rdy),
    .msg_nf_vld    (msg_nf_vld),
    .msg_nf_rdy    (msg_nf_rdy),
    .fwd_discard   (fwd_discard),
    .fwd_continue  (fwd_continue),
    .stat_q        (stat_q),
    .fep_valid_q   (fep_valid_q),
    .fep_idx_q     (fep_idx_q)
);

// File: tb/bridge_err_report_test.sv
`timescale 1ns/1ps
module bridge_err_report_test;
    localparam logic [2:0] SEV_RST = 3'b010;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_par = 0, ev_spin = 0, ev_mabt = 0;
    logic [31:0] ev_hdr = '0;
    logic        reg_wr_en = 0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        msg_fatal_vld, msg_nf_vld, fwd_discard, fwd_continue;
    logic        msg_fatal_rdy = 1, msg_nf_rdy = 1;

    int total = 0;
    int bad = 0;

    // reference state built from the requirements
    logic [2:0]  m_st, m_msk, m_sev, m_ctl, m_leg;
    logic [1:0]  m_dev, m_idx;
    logic        m_fv, m_pf, m_pn, m_disc, m_cont;
    logic [31:0] m_hlog;

    always #2.5 clk = ~clk;

    bridge_err_report #(.HDR_W(32), .SEV_RST(SEV_RST)) uut (
        .clk(clk), .rst_n(rst_n), .ev_par(ev_par), .ev_spin(ev_spin),
        .ev_mabt(ev_mabt), .ev_hdr(ev_hdr), .reg_wr_en(reg_wr_en),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .msg_fatal_vld(msg_fatal_vld), .msg_fatal_rdy(msg_fatal_rdy),
        .msg_nf_vld(msg_nf_vld), .msg_nf_rdy(msg_nf_rdy),
        .fwd_discard(fwd_discard), .fwd_continue(fwd_continue));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_reg(input logic [2:0] a);
        case (a)
            3'd0: return {29'd0, m_st};
            3'd1: return {29'd0, m_msk};
            3'd2: return {29'd0, m_sev};
            3'd3: return {27'd0, m_fv, 2'b00, m_idx};
            3'd4: return m_hlog;
            3'd5: return {29'd0, m_ctl};
            3'd6: return {29'd0, m_leg};
            default: return {30'd0, m_dev};
        endcase
    endfunction

    function automatic string reg_tag(input logic [2:0] a);
        case (a)
            3'd0: return "R2 status";
            3'd1: return "R1 mask";
            3'd2: return "R8 severity";
            3'd3: return "R6 pointer";
            3'd4: return "R3 header log";
            3'd5: return "R1 control";
            3'd6: return "R10 legacy";
            default: return "R11 device";
        endcase
    endfunction

    task automatic model_reset();
        m_st = 0; m_msk = 0; m_sev = SEV_RST; m_ctl = 0; m_leg = 0; m_dev = 0;
        m_idx = 0; m_fv = 0; m_pf = 0; m_pn = 0; m_disc = 0; m_cont = 0; m_hlog = 0;
    endtask

    // read one register combinationally, away from the clock edge
    task automatic rd(input logic [2:0] a, input string tag);
        reg_wr_en = 0;
        reg_addr  = a;
        #0.1;
        chk(tag, reg_rdata, exp_reg(a));
    endtask

    task automatic read_all(input string tag);
        for (int a = 0; a < 8; a++) rd(3'(a), tag);
    endtask

    // one clock: drive at the falling edge, advance the model, compare after the rise
    task automatic step(input logic p, input logic s, input logic m, input logic [31:0] h,
                        input logic wr, input logic [2:0] a, input logic [31:0] d,
                        input logic fr, input logic nr);
        logic [2:0] ev, clr, lclr, req, claim, nst;
        logic [1:0] dclr;
        logic f_new, n_new;
        int w;
        @(negedge clk);
        ev_par = p; ev_spin = s; ev_mabt = m; ev_hdr = h;
        reg_wr_en = wr; reg_addr = a; reg_wdata = d;
        msg_fatal_rdy = fr; msg_nf_rdy = nr;
        ev   = {m, s, p};
        clr  = (wr && a == 3'd0) ? d[2:0] : 3'd0;
        lclr = (wr && a == 3'd6) ? d[2:0] : 3'd0;
        dclr = (wr && a == 3'd7) ? d[1:0] : 2'd0;
        for (int i = 0; i < 3; i++) begin
            req[i]   = ev[i] && !m_msk[i] &&
                       (m_ctl[0] || (m_sev[i] ? m_ctl[1] : m_ctl[2]));
            claim[i] = ev[i] && !m_msk[i] && (i == 0 || !m_fv);
        end
        f_new = |(req & m_sev);
        n_new = |(req & ~m_sev);
        nst = (m_st & ~clr) | ev;
        w = claim[0] ? 0 : claim[1] ? 1 : claim[2] ? 2 : -1;
        if (w >= 0) begin
            m_idx = 2'(w);
            m_fv  = 1;
            if (w != 1) m_hlog = h;
        end else begin
            m_fv = m_fv && nst[m_idx];
        end
        m_leg = (m_leg & ~lclr) | {m, s, m_ctl[0] & (f_new | n_new)};
        m_dev = (m_dev & ~dclr) | {|(ev & ~m_sev), |(ev & m_sev)};
        m_pf  = (m_pf & !fr) | f_new;
        m_pn  = (m_pn & !nr) | n_new;
        m_disc = m; m_cont = s;
        m_st = nst;
        if (wr && a == 3'd1) m_msk = d[2:0];
        if (wr && a == 3'd2) m_sev = d[2:0];
        if (wr && a == 3'd5) m_ctl = d[2:0];
        @(posedge clk);
        #1;
        chk("R9 fatal valid", {31'd0, msg_fatal_vld}, {31'd0, m_pf});
        chk("R9 non-fatal valid", {31'd0, msg_nf_vld}, {31'd0, m_pn});
        chk("R12 discard", {31'd0, fwd_discard}, {31'd0, m_disc});
        chk("R12 continue", {31'd0, fwd_continue}, {31'd0, m_cont});
    endtask

    task automatic idle(); step(0,0,0,0, 0,0,0, 1,1); endtask
    task automatic wreg(input logic [2:0] a, input logic [31:0] d); step(0,0,0,0, 1,a,d, 1,1); endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        #0.1;
        chk("R1 reset fatal valid", {31'd0, msg_fatal_vld}, 32'd0);
        chk("R1 reset discard", {31'd0, fwd_discard}, 32'd0);
        read_all("R1 reset value");

        // R3: parity logs header and keeps overwriting the pointer
        wreg(3'd5, 32'd1);
        step(1,0,0,32'hA5A5_0001, 0,0,0, 1,1);
        read_all("R3 parity capture");
        step(0,1,0,32'h1111_2222, 0,0,0, 1,1);
        read_all("R4 spin with pointer valid");
        step(0,0,1,32'h3333_4444, 0,0,0, 1,1);
        read_all("R5 abort with pointer valid");
        step(1,0,0,32'hA5A5_0002, 0,0,0, 1,1);
        read_all("R3 parity overwrite");

        // R7: clearing the pointed bit invalidates the pointer
        wreg(3'd0, 32'd1);
        read_all("R7 pointer dropped");
        wreg(3'd0, 32'd6);
        step(0,1,0,32'h5555_6666, 0,0,0, 1,1);
        read_all("R4 spin takes pointer, no log");
        wreg(3'd0, 32'd2);
        step(0,0,1,32'h7777_8888, 0,0,0, 1,1);
        read_all("R5 abort takes pointer and log");

        // R6: simultaneous events, then spin+abort only
        wreg(3'd0, 32'd7);
        step(1,1,1,32'h9999_0000, 0,0,0, 1,1);
        read_all("R6 all three");
        wreg(3'd0, 32'd7);
        step(0,1,1,32'hBBBB_0000, 0,0,0, 1,1);
        read_all("R6 spin over abort");

        // R2: set wins over a same-cycle clear
        step(1,0,0,32'hCCCC_0000, 1,3'd0,32'd7, 1,1);
        read_all("R2 set beats clear");

        // R8/R10: gating by mask and enables
        wreg(3'd5, 32'd0);
        step(1,1,1,32'h0, 0,0,0, 1,1);
        read_all("R10 no request no legacy");
        wreg(3'd6, 32'd7);
        wreg(3'd5, 32'd2);
        step(0,1,0,32'h0, 0,0,0, 1,1);
        step(1,0,0,32'h0, 0,0,0, 1,1);
        read_all("R8 fatal enable only");
        wreg(3'd1, 32'd7);
        wreg(3'd5, 32'd7);
        step(1,1,1,32'h0, 0,0,0, 1,1);
        read_all("R11 masked still detected");
        wreg(3'd1, 32'd0);

        // R9: hold with ready low, merge, then accept
        step(1,0,0,32'h0, 0,0,0, 0,0);
        step(0,1,0,32'h0, 0,0,0, 0,0);
        step(1,0,0,32'h0, 0,0,0, 0,0);
        idle(); idle();
        step(0,0,0,32'h0, 0,0,0, 1,0);
        step(0,0,0,32'h0, 0,0,0, 0,1);
        idle();

        // random phase
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] r;
            logic [2:0]  a;
            r = $urandom;
            a = 3'($urandom_range(0, 7));
            step(r[0] & r[1], r[2] & r[3], r[4] & r[5], $urandom,
                 (r[8:6] == 3'd0), a, {29'd0, 3'(r[14:12])},
                 r[16] | r[17], r[18] | r[19]);
            if (n % 40 == 0)
                for (int k = 0; k < 8; k++) rd(3'(k), reg_tag(3'(k)));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule